// File: doc/BRIEF.md
# Gated SD Card Clock Divider

This block derives a card clock for an SD/eMMC interface, plus an auxiliary high-speed clock, from a single source clock. A 32-bit control word sets a two-stage division. The first stage is a power-of-two pre-divider with ratios 1 to 16. The second stage is a fixed /2 or /4. The card clock ratio is the product of the two stages, so it runs from 2 to 64. Both outputs come straight from flops and have a 50% duty cycle.

Two stop bits gate the card clock and the auxiliary clock independently. Software can write the whole word with one strobe. Two one-cycle commands give a quick disable and a quick enable. On enable, the auxiliary stop bit is set again when the pre-divider setting requires it. A suspend strobe saves the control word in a shadow, and a resume strobe writes the shadow back.

A new setting never reaches the outputs in the middle of a clock phase. It waits for the end of a card-clock low phase. An unsupported division code holds both clocks low and sets a sticky error flag. All controls are plain one-cycle strobes and levels. The block carries no data stream, so no port has back-pressure.

Top module: `sdclk_gen`

## Requirements
- R1: The reset is synchronous and active low. After reset with `skip_first` low, the control word reads 0x00000301: both stop bits set, pre code 0 and post code 1. `card_clk`, `hs_clk` and `div_err` are low after reset.
- R2: Control bit 9 stops the auxiliary clock and control bit 8 stops the card clock. `clk_enabled` is high only when both bits are clear.
- R3: Bits 4:2 hold the pre code. Codes 0, 1, 2, 3 and 4 divide by 1, 2, 4, 8 and 16. Bits 1:0 hold the post code: code 0 divides by 2 and code 1 by 4. `card_clk` has a period equal to the product of the two ratios and is high for exactly half of it.
- R4: `hs_clk` has a period of twice the pre-divider ratio with a 50% duty cycle. It runs whenever bit 9 is clear, whatever the value of bit 8, and it is held low while bit 9 is set.
- R5: `gate_off` sets both stop bits. `gate_on` clears bit 8 and sets bit 9 to 1 exactly when the pre code is 2 or more. Either command shows in the control word one edge after its strobe. When several strobes arrive in one cycle, resume wins over write, write over `gate_off`, and `gate_off` over `gate_on`.
- R6: A `reg_wr` strobe replaces bits 9:8 and 4:0 together, one edge later. Other write bits change nothing. Read bits other than 9:8, 4:0 and 16 are zero.
- R7: A pre code from 5 to 7 or a post code of 2 or 3 is illegal. With an illegal code, both clocks are held low and the error flag is set (`div_err`, read bit 16). The flag stays set until a write of a legal setting with bit 16 set to 1.
- R8: A new setting reaches the outputs only at the end of a card-clock low phase. It is taken at once if both clocks are stopped or the current setting is illegal. Every completed high pulse of `card_clk` lasts exactly half the period of a setting that was in force.
- R9: `suspend_req` copies the control word into a shadow. `resume_req` writes the shadow back, and the result is visible one edge later.
- R10: After a reset with `skip_first` high, the control word reads 0x00000305, which is pre code 1 and post code 1 with both stops set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| skip_first | input | 1 | Picks the reset default of the control word (pre /2 instead of /1) |
| reg_wr | input | 1 | One-cycle write strobe for the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Control word readback, error flag in bit 16 |
| gate_on | input | 1 | One-cycle enable command |
| gate_off | input | 1 | One-cycle disable command |
| suspend_req | input | 1 | One-cycle capture of the control word |
| resume_req | input | 1 | One-cycle restore of the captured word |
| card_clk | output | 1 | Divided card clock |
| hs_clk | output | 1 | Auxiliary clock at twice the pre-divider ratio |
| clk_enabled | output | 1 | High when neither stop bit is set |
| div_err | output | 1 | Sticky illegal-code flag |

## Verification
Writes, commands, save and restore change `reg_rdata`, `clk_enabled` and `div_err` one rising edge after the strobe. The bench reads them at the falling edge that follows. A clock change must first wait for the end of the running card low phase, which takes at most 64 source cycles, and then pass one output flop. The bench therefore waits 140 cycles before it measures. It counts rising edges and high samples over a 256-cycle window, which is a whole multiple of every legal period, so the counts do not depend on phase. The glitch test switches the rate in the middle of a long high pulse and then sorts every completed high pulse by its length.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  localparam int REG_W         = 32;
  localparam int PRE_W         = 3;
  localparam int POST_W        = 2;
  localparam int PRE_LSB       = 2;
  localparam int POST_LSB      = 0;
  localparam int STOP_CARD_BIT = 8;
  localparam int STOP_HS_BIT   = 9;
  localparam int ERR_BIT       = 16;
  localparam int NUM_PRE       = 5;            // legal pre codes 0..NUM_PRE-1
  localparam int NUM_POST      = 2;            // legal post codes 0..NUM_POST-1
  localparam int HS_STOP_FROM  = 2;            // pre codes at/above this keep hs stopped
  localparam int CNT_W         = NUM_PRE - 1;  // counts up to 2**(NUM_PRE-1)-1
  localparam int NUM_OUT       = 2;
  localparam int OUT_CARD      = 0;
  localparam int OUT_HS        = 1;

  typedef struct packed {
    logic              stop_hs;
    logic              stop_card;
    logic [PRE_W-1:0]  pre;
    logic [POST_W-1:0] post;
  } div_cfg_t;

  function automatic logic cfg_legal(input div_cfg_t c);
    return (int'(c.pre) < NUM_PRE) && (int'(c.post) < NUM_POST);
  endfunction

  function automatic logic hs_stop_for(input logic [PRE_W-1:0] pre);
    return int'(pre) >= HS_STOP_FROM;
  endfunction

  function automatic div_cfg_t default_cfg(input logic skip);
    div_cfg_t c;
    c.stop_hs   = 1'b1;
    c.stop_card = 1'b1;
    c.pre       = skip ? PRE_W'(1) : PRE_W'(0);
    c.post      = POST_W'(1);
    return c;
  endfunction

  function automatic logic [CNT_W-1:0] pre_limit(input logic [PRE_W-1:0] pre);
    return CNT_W'((1 << pre) - 1);
  endfunction

  function automatic logic [REG_W-1:0] cfg_to_word(input div_cfg_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[STOP_HS_BIT]            = c.stop_hs;
    w[STOP_CARD_BIT]          = c.stop_card;
    w[PRE_LSB +: PRE_W]       = c.pre;
    w[POST_LSB +: POST_W]     = c.post;
    return w;
  endfunction
endpackage

// File: rtl/sdclk_ctrl_reg.sv
module sdclk_ctrl_reg
  import sdclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             skip_first,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             gate_on,
  input  logic             gate_off,
  input  logic             suspend_req,
  input  logic             resume_req,
  output div_cfg_t         cfg,
  output logic             err,
  output logic [REG_W-1:0] rdata
);
  div_cfg_t cfg_n;
  div_cfg_t saved;
  div_cfg_t wr_cfg;
  logic     err_clr;
  logic     unused_wbits;

  assign unused_wbits = ^reg_wdata;

  always_comb begin
    wr_cfg.stop_hs   = reg_wdata[STOP_HS_BIT];
    wr_cfg.stop_card = reg_wdata[STOP_CARD_BIT];
    wr_cfg.pre       = reg_wdata[PRE_LSB +: PRE_W];
    wr_cfg.post      = reg_wdata[POST_LSB +: POST_W];
  end

  // priority: resume > write > gate_off > gate_on
  always_comb begin
    cfg_n = cfg;
    if (resume_req) begin
      cfg_n = saved;
    end else if (reg_wr) begin
      cfg_n = wr_cfg;
    end else if (gate_off) begin
      cfg_n.stop_hs   = 1'b1;
      cfg_n.stop_card = 1'b1;
    end else if (gate_on) begin
      cfg_n.stop_card = 1'b0;
      cfg_n.stop_hs   = hs_stop_for(cfg.pre);
    end
  end

  assign err_clr = reg_wr && !resume_req && reg_wdata[ERR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg   <= default_cfg(skip_first);
      saved <= default_cfg(skip_first);
      err   <= 1'b0;
    end else begin
      cfg <= cfg_n;
      if (suspend_req) saved <= cfg;
      err <= (err && !err_clr) || !cfg_legal(cfg_n);
    end
  end

  assign rdata = cfg_to_word(cfg) | (REG_W'(err) << ERR_BIT);
endmodule

// File: rtl/sdclk_div_core.sv
module sdclk_div_core
  import sdclk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  div_cfg_t want,
  output logic     card_clk,
  output logic     hs_clk
);
  div_cfg_t           act, act_n;
  logic [CNT_W-1:0]   pre_cnt, pre_cnt_n;
  logic               half_cnt, half_cnt_n;
  logic [NUM_OUT-1:0] ph, ph_n, stop_n, out_q;
  logic               act_ok, tick, half_end, boundary, idle, load;

  always_comb begin
    act_ok   = cfg_legal(act);
    tick     = act_ok && (pre_cnt == pre_limit(act.pre));
    half_end = tick && (half_cnt == act.post[0]);
    boundary = half_end && !ph[OUT_CARD];
    idle     = !act_ok || (act.stop_card && act.stop_hs);
    load     = (want != act) && (idle || boundary);

    act_n      = act;
    pre_cnt_n  = pre_cnt;
    half_cnt_n = half_cnt;
    ph_n       = ph;
    if (load) begin
      act_n      = want;
      pre_cnt_n  = '0;
      half_cnt_n = 1'b0;
      ph_n       = '0;
    end else if (!act_ok) begin
      pre_cnt_n  = '0;
      half_cnt_n = 1'b0;
      ph_n       = '0;
    end else if (tick) begin
      pre_cnt_n      = '0;
      ph_n[OUT_HS]   = ~ph[OUT_HS];
      if (half_end) begin
        half_cnt_n     = 1'b0;
        ph_n[OUT_CARD] = ~ph[OUT_CARD];
      end else begin
        half_cnt_n = 1'b1;
      end
    end else begin
      pre_cnt_n = pre_cnt + 1'b1;
    end

    stop_n[OUT_CARD] = act_n.stop_card || !cfg_legal(act_n);
    stop_n[OUT_HS]   = act_n.stop_hs   || !cfg_legal(act_n);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act      <= default_cfg(1'b0);
      pre_cnt  <= '0;
      half_cnt <= 1'b0;
      ph       <= '0;
    end else begin
      act      <= act_n;
      pre_cnt  <= pre_cnt_n;
      half_cnt <= half_cnt_n;
      ph       <= ph_n;
    end
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_gate
    logic q;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= 1'b0;
      else        q <= ph_n[g] && !stop_n[g];
    end
    assign out_q[g] = q;
  end

  assign card_clk = out_q[OUT_CARD];
  assign hs_clk   = out_q[OUT_HS];
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
  import sdclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             skip_first,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             gate_on,
  input  logic             gate_off,
  input  logic             suspend_req,
  input  logic             resume_req,
  output logic             card_clk,
  output logic             hs_clk,
  output logic             clk_enabled,
  output logic             div_err
);
  div_cfg_t cfg;

  sdclk_ctrl_reg u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .skip_first  (skip_first),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .gate_on     (gate_on),
    .gate_off    (gate_off),
    .suspend_req (suspend_req),
    .resume_req  (resume_req),
    .cfg         (cfg),
    .err         (div_err),
    .rdata       (reg_rdata)
  );

  sdclk_div_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .want     (cfg),
    .card_clk (card_clk),
    .hs_clk   (hs_clk)
  );

  assign clk_enabled = !cfg.stop_card && !cfg.stop_hs;
endmodule

// File: rtl/sdclk_gen_chk.sv
module sdclk_gen_chk
  import sdclk_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             skip_first,
  input logic             reg_wr,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic             gate_on,
  input logic             gate_off,
  input logic             suspend_req,
  input logic             resume_req,
  input logic             card_clk,
  input logic             hs_clk,
  input logic             div_err
);
  localparam logic [9:0] FMASK = 10'h31F;

  logic [7:0] card_run, hs_run, ill_cnt;
  logic [9:0] shadow;
  logic       ill_now;
  logic       unused_bits;

  assign unused_bits = ^{reg_wdata, reg_rdata};
  assign ill_now = (reg_rdata[4:2] > 3'd4) || (reg_rdata[1:0] > 2'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      card_run <= '0;
      hs_run   <= '0;
      ill_cnt  <= '0;
      shadow   <= 10'h301 | (10'(skip_first) << 2);
    end else begin
      card_run <= card_clk ? ((card_run == 8'hFF) ? card_run : card_run + 8'd1) : 8'd0;
      hs_run   <= hs_clk   ? ((hs_run   == 8'hFF) ? hs_run   : hs_run   + 8'd1) : 8'd0;
      ill_cnt  <= ill_now  ? ((ill_cnt  == 8'hFF) ? ill_cnt  : ill_cnt  + 8'd1) : 8'd0;
      if (suspend_req) shadow <= reg_rdata[9:0] & FMASK;
    end
  end

  a_r1_reset_outputs_low: assert property (@(posedge clk)
    !rst_n |=> (!card_clk && !hs_clk && !div_err));

  a_r1_reset_stops_set: assert property (@(posedge clk)
    !rst_n |=> (reg_rdata[9:8] == 2'b11));

  a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !resume_req) |=> ((reg_rdata[9:0] & FMASK) == ($past(reg_wdata[9:0]) & FMASK)));

  a_r5_gate_off_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_off && !reg_wr && !resume_req) |=> (reg_rdata[9:8] == 2'b11));

  a_r5_gate_on_rule: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_on && !gate_off && !reg_wr && !resume_req) |=>
      (!reg_rdata[8] && (reg_rdata[9] == ($past(reg_rdata[4:2]) >= 3'd2))));

  a_r9_resume_restores: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req |=> ((reg_rdata[9:0] & FMASK) == $past(shadow)));

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (div_err && !(reg_wr && !resume_req && reg_wdata[16])) |=> div_err);

  a_r7_illegal_held_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ill_cnt >= 8'd80) |-> (!card_clk && !hs_clk));

  a_r8_card_half_period: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(card_clk) |-> (($countones(card_run) == 1) && (card_run <= 8'd32)));

  a_r4_hs_half_period: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_clk) |-> (($countones(hs_run) == 1) && (hs_run <= 8'd16)));
endmodule

bind sdclk_gen sdclk_gen_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .skip_first  (skip_first),
  .reg_wr      (reg_wr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .gate_on     (gate_on),
  .gate_off    (gate_off),
  .suspend_req (suspend_req),
  .resume_req  (resume_req),
  .card_clk    (card_clk),
  .hs_clk      (hs_clk),
  .div_err     (div_err)
);

// File: tb/sdclk_gen_test.sv
module sdclk_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        skip_first = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        gate_on = 1'b0, gate_off = 1'b0, suspend_req = 1'b0, resume_req = 1'b0;
  logic        card_clk, hs_clk, clk_enabled, div_err;
  int          checks = 0;
  int          failures = 0;

  always #2 clk = ~clk;

  sdclk_gen uut (
    .clk(clk), .rst_n(rst_n), .skip_first(skip_first),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .gate_on(gate_on), .gate_off(gate_off),
    .suspend_req(suspend_req), .resume_req(resume_req),
    .card_clk(card_clk), .hs_clk(hs_clk),
    .clk_enabled(clk_enabled), .div_err(div_err)
  );

  localparam int NV = 12;
  localparam logic [31:0] V_DATA [NV] = '{32'h000, 32'h001, 32'h005, 32'h204, 32'h209, 32'h20D,
                                          32'h211, 32'h210, 32'h10C, 32'h300, 32'h002, 32'h01C};
  localparam int V_CARD [NV] = '{2, 4, 8, 4, 16, 32, 64, 32, 0, 0, 0, 0};
  localparam int V_HS   [NV] = '{2, 2, 4, 0, 0, 0, 0, 0, 16, 0, 0, 0};
  localparam int V_ERR  [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1};

  task automatic check(input string req, input string what, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic write_word(input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // sel = {gate_on, gate_off, suspend_req, resume_req}
  task automatic strobe(input logic [3:0] sel);
    @(negedge clk);
    {gate_on, gate_off, suspend_req, resume_req} = sel;
    @(negedge clk);
    {gate_on, gate_off, suspend_req, resume_req} = 4'b0000;
  endtask

  task automatic measure(output int c_rise, output int c_high, output int h_rise, output int h_high);
    logic pc, ph;
    @(negedge clk);
    pc = card_clk;
    ph = hs_clk;
    c_rise = 0; c_high = 0; h_rise = 0; h_high = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (card_clk) c_high++;
      if (card_clk && !pc) c_rise++;
      if (hs_clk) h_high++;
      if (hs_clk && !ph) h_rise++;
      pc = card_clk;
      ph = hs_clk;
    end
  endtask

  task automatic check_rate(input string req, input int card_ratio, input int hs_ratio);
    int cr, ch, hr, hh;
    repeat (140) @(negedge clk);
    measure(cr, ch, hr, hh);
    check(req, "card rises", cr, (card_ratio == 0) ? 0 : 256 / card_ratio);
    check(req, "card highs", ch, (card_ratio == 0) ? 0 : 128);
    check("R4", "hs rises", hr, (hs_ratio == 0) ? 0 : 256 / hs_ratio);
    check("R4", "hs highs", hh, (hs_ratio == 0) ? 0 : 128);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int hrun, n_old, n_new, n_bad;
    logic prev;

    // R1 reset state
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "rdata", reg_rdata, 32'h301);
    check("R1", "card_clk", card_clk, 0);
    check("R1", "hs_clk", hs_clk, 0);
    check("R1", "div_err", div_err, 0);
    check("R2", "clk_enabled at reset", clk_enabled, 0);

    // table walk: R3 ratios, R4 hs, R2 stops, R7 illegal codes
    for (int v = 0; v < NV; v++) begin
      write_word(V_DATA[v]);
      check("R6", "rdata after write", reg_rdata, V_DATA[v] | (32'(V_ERR[v]) << 16));
      check("R7", "div_err", div_err, V_ERR[v]);
      check("R2", "clk_enabled", clk_enabled, (V_DATA[v][9:8] == 2'b00) ? 1 : 0);
      check_rate((V_ERR[v] != 0) ? "R7" : "R3", V_CARD[v], V_HS[v]);
    end

    // R6 ignored bits and R7 error clear
    write_word(32'hABCD_FCE5);
    check("R6", "ignored write bits", reg_rdata, 32'h0000_0005);
    check("R7", "err cleared", div_err, 0);

    // R5 gate commands
    write_word(32'h301);
    strobe(4'b1000);
    check("R5", "gate_on pre0", reg_rdata, 32'h001);
    check("R2", "enabled after gate_on", clk_enabled, 1);
    check_rate("R5", 4, 2);
    strobe(4'b0100);
    check("R5", "gate_off", reg_rdata, 32'h301);
    check("R2", "enabled after gate_off", clk_enabled, 0);
    check_rate("R5", 0, 0);
    write_word(32'h309);
    strobe(4'b1000);
    check("R5", "gate_on pre2 keeps hs stop", reg_rdata, 32'h209);
    check("R2", "enabled with hs stop", clk_enabled, 0);
    check_rate("R5", 16, 0);

    // R9 suspend and resume
    write_word(32'h005);
    strobe(4'b0010);
    write_word(32'h211);
    check("R9", "changed after suspend", reg_rdata, 32'h211);
    strobe(4'b0001);
    check("R9", "restored", reg_rdata, 32'h005);
    check_rate("R9", 8, 4);

    // R8 rate change in mid high phase: only full-length high pulses
    write_word(32'h211);
    repeat (150) @(negedge clk);
    while (card_clk) @(negedge clk);
    while (!card_clk) @(negedge clk);
    hrun = 1; n_old = 0; n_new = 0; n_bad = 0; prev = 1'b1;
    for (int i = 1; i < 400; i++) begin
      if (i == 15) begin reg_wr = 1'b1; reg_wdata = 32'h000; end
      if (i == 16) reg_wr = 1'b0;
      @(negedge clk);
      if (card_clk) hrun++;
      else if (prev) begin
        if (hrun == 32) n_old++;
        else if (hrun == 1) n_new++;
        else n_bad++;
        hrun = 0;
      end
      prev = card_clk;
    end
    check("R8", "old high pulses kept whole", n_old, 1);
    check("R8", "runt pulses", n_bad, 0);
    check("R8", "new rate reached", (n_new >= 100) ? 1 : 0, 1);

    // R10 skip-first default
    @(negedge clk);
    skip_first = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "rdata", reg_rdata, 32'h305);
    check("R10", "card_clk low", card_clk, 0);
    strobe(4'b1000);
    check("R10", "gate_on from skip default", reg_rdata, 32'h005);
    check_rate("R10", 8, 4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule